// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block owns the program counter of a simple 32-bit in-order core whose control transfers are delayed by one instruction. Every clock cycle it looks at the instruction word fetched from the current PC, together with a taken flag from the branch comparator and a flag from the decoder marking an unconditional jump, and it decides which address to fetch next.

A taken branch or a jump does not redirect fetch at once. The target is computed and parked in a one-entry pending register, the instruction right after the transfer (the delay slot) is fetched and executed at PC+4, and only on the following cycle does the PC load the parked target. The branch comparison itself is done outside; this block only consumes its result.

Top module: `pcseq_top`

## Requirements
- R1: `rst_n` is a synchronous active-low reset. While it is low at a rising edge, the PC becomes RESET_PC (0 by default) and any parked target is discarded, so the cycles after release count up from RESET_PC by 4.
- R2: With no parked target, no jump and no taken branch, the next PC is the current PC plus 4.
- R3: A taken branch targets (PC+4) plus the sign-extended `instr[15:0]` shifted left by 2, wrapping modulo 2^32.
- R4: A jump targets the concatenation of bits 31:28 of PC+4, `instr[25:0]` and two zero bits.
- R5: The cycle after a jump or taken branch is accepted, the PC is the accepted instruction's PC plus 4 (the delay slot runs).
- R6: The cycle after the delay slot, the PC equals the parked target; the parked target is then dropped, so the slot after the target proceeds sequentially.
- R7: A jump or taken branch presented while a target is parked (that is, in a delay slot) has no effect: the PC still moves to the parked target and then continues sequentially from it.
- R8: When `jump_en` and `branch_taken` are both high on an accepted cycle, the jump target wins.
- R9: With `branch_taken` low and `jump_en` low, the branch offset field in `instr` has no effect on the PC sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 32 | Instruction word fetched at the current PC |
| branch_taken | input | 1 | Branch condition evaluated true for this instruction |
| jump_en | input | 1 | This instruction is an unconditional jump |
| pc | output | 32 | Current program counter |

## Verification
The assertions take for granted that `branch_taken` and `jump_en` are driven to known values every cycle after reset and that `instr` belongs to the PC shown on `pc` in the same cycle; nothing is assumed about the two flags being exclusive. The stimulus changes inputs only on falling edges, feeds each instruction exactly once per PC, and deliberately places transfers inside delay slots, raises both flags together, and asserts reset while a target is parked, so that the priority and suppression paths are reached without leaving those assumptions.

// File: rtl/pcseq_pkg.sv
// Shared types for the delay-slot PC sequencer.
// Assumes: nothing beyond being compiled before the modules that import it.
package pcseq_pkg;

    // Source of the next program counter value
    typedef enum logic {
        NPC_SEQUENTIAL = 1'b0,
        NPC_PARKED     = 1'b1
    } npc_src_e;

    // Kind of transfer chosen for the pending register
    typedef enum logic {
        XFER_BRANCH = 1'b0,
        XFER_JUMP   = 1'b1
    } xfer_kind_e;

endpackage

// File: rtl/pcseq_target_calc.sv
// Computes the three candidate addresses for the current instruction:
// the sequential successor, the relative branch target and the
// region-relative jump target.
// Assumes: pc is word aligned; the offset and index fields are taken
// from the instruction word by the caller.
module pcseq_target_calc #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int IDX_W  = 26
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [IDX_W-1:0]  index_i,
    output logic [ADDR_W-1:0] seq_o,
    output logic [ADDR_W-1:0] branch_o,
    output logic [ADDR_W-1:0] jump_o
);
    localparam int SHIFT    = 2;
    localparam int STEP     = 1 << SHIFT;
    localparam int EXT_W    = ADDR_W - OFF_W - SHIFT;
    localparam int REGION_W = ADDR_W - IDX_W - SHIFT;

    logic [ADDR_W-1:0] disp;

    // Sequential successor and sign-extended word displacement
    always_comb begin
        seq_o  = pc_i + ADDR_W'(STEP);
        disp   = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, {SHIFT{1'b0}}};
        branch_o = seq_o + disp;
    end

    // Jump target: keep the region bits of PC+4 when the index leaves any
    generate
        if (REGION_W > 0) begin : g_region
            always_comb jump_o = {seq_o[ADDR_W-1 -: REGION_W], index_i, {SHIFT{1'b0}}};
        end else begin : g_flat
            always_comb jump_o = {index_i[ADDR_W-SHIFT-1:0], {SHIFT{1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/pcseq_pending.sv
// One-entry holding register for a transfer target waiting out its
// delay slot. A load sets the valid flag for exactly one cycle.
// Assumes: the caller never asserts load while valid is already set.
module pcseq_pending #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] target_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] target_o
);

    // Capture a new target, or drop the one just consumed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o  <= 1'b0;
            target_o <= '0;
        end else if (load_i) begin
            valid_o  <= 1'b1;
            target_o <= target_i;
        end else begin
            valid_o  <= 1'b0;
        end
    end

    // R6: a parked target lives for a single cycle
    park_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o)
        else $error("parked target held longer than one cycle");

    // R7: no capture is requested while a target is parked
    no_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !load_i)
        else $error("capture requested inside a delay slot");

endmodule

// File: rtl/pcseq_top.sv
// Program counter sequencer with a single delay slot. Holds the PC,
// accepts a jump or taken branch only when no target is parked, and
// redirects fetch one instruction after the accepted transfer.
// Assumes: instr belongs to the PC on pc in the same cycle; the flags
// are known after reset.
module pcseq_top #(
    parameter int                ADDR_W   = 32,
    parameter int                INSTR_W  = 32,
    parameter int                OFF_W    = 16,
    parameter int                IDX_W    = 26,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic               branch_taken,
    input  logic               jump_en,
    output logic [ADDR_W-1:0]  pc
);
    import pcseq_pkg::*;

    localparam int STEP = 4;

    logic [ADDR_W-1:0] seq_pc, br_tgt, jmp_tgt, chosen_tgt, parked_tgt, next_pc;
    logic              parked_v, accept;
    xfer_kind_e        kind;
    npc_src_e          src;
    logic              unused_instr_bits;

    assign unused_instr_bits = ^instr[INSTR_W-1:IDX_W];

    pcseq_target_calc #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W)
    ) calc_i (
        .pc_i     (pc),
        .offset_i (instr[OFF_W-1:0]),
        .index_i  (instr[IDX_W-1:0]),
        .seq_o    (seq_pc),
        .branch_o (br_tgt),
        .jump_o   (jmp_tgt)
    );

    // Decide whether a transfer is accepted and which target it parks
    always_comb begin
        accept     = (jump_en || branch_taken) && !parked_v;
        kind       = jump_en ? XFER_JUMP : XFER_BRANCH;
        chosen_tgt = (kind == XFER_JUMP) ? jmp_tgt : br_tgt;
    end

    pcseq_pending #(
        .ADDR_W (ADDR_W)
    ) park_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .target_i (chosen_tgt),
        .valid_o  (parked_v),
        .target_o (parked_tgt)
    );

    // Pick the next PC: parked target wins over the sequential successor
    always_comb begin
        src = parked_v ? NPC_PARKED : NPC_SEQUENTIAL;
        unique case (src)
            NPC_PARKED:     next_pc = parked_tgt;
            default:        next_pc = seq_pc;
        endcase
    end

    // Program counter register
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= RESET_PC;
        else        pc <= next_pc;
    end

    // R1
    reset_pc_chk: assert property (@(posedge clk)
        !rst_n |=> pc == RESET_PC)
        else $error("PC not at reset value after reset");

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!parked_v && !jump_en && !branch_taken) |=> pc == $past(pc) + ADDR_W'(STEP))
        else $error("sequential step wrong");

    // R5
    delay_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!parked_v && (jump_en || branch_taken)) |=> (pc == $past(pc) + ADDR_W'(STEP)) && parked_v)
        else $error("delay slot skipped");

    // R6
    land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        parked_v |=> pc == $past(parked_tgt))
        else $error("PC did not land on parked target");

    // R8
    jump_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!parked_v && jump_en && branch_taken) |=> parked_tgt == $past(jmp_tgt))
        else $error("branch target parked instead of jump target");

endmodule

// File: tb/pcseq_top_tb.sv
module pcseq_top_tb_top;

    typedef struct packed {
        logic [31:0] instr;
        logic        br;
        logic        jmp;
        logic [31:0] exp_pc;
    } vec_t;

    localparam int NVEC = 11;
    // exp_pc is the PC shown in the cycle these inputs are applied
    localparam vec_t VEC [NVEC] = '{
        '{32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000},  // R2 plain
        '{32'h1000_0003, 1'b1, 1'b0, 32'h0000_0004},  // R3 branch +3 words -> 0x14
        '{32'h0000_0000, 1'b0, 1'b0, 32'h0000_0008},  // R5 delay slot
        '{32'h1000_FFFE, 1'b1, 1'b0, 32'h0000_0014},  // R6 landed; R3 branch -2 -> 0x10
        '{32'h0800_0123, 1'b0, 1'b1, 32'h0000_0018},  // R7 jump in slot ignored
        '{32'h1000_0777, 1'b0, 1'b0, 32'h0000_0010},  // R9 offset field, not taken
        '{32'h0800_0040, 1'b0, 1'b1, 32'h0000_0014},  // R4 jump -> 0x100
        '{32'h1000_0005, 1'b1, 1'b0, 32'h0000_0018},  // R7 branch in slot ignored
        '{32'h0000_0010, 1'b1, 1'b1, 32'h0000_0100},  // R8 both: jump 0x40 wins
        '{32'h0000_0000, 1'b0, 1'b0, 32'h0000_0104},  // R5 slot
        '{32'h0000_0000, 1'b0, 1'b0, 32'h0000_0040}   // R8 landed on jump target
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic        branch_taken = 1'b0;
    logic        jump_en = 1'b0;
    logic [31:0] pc;

    logic        rst_h = 1'b0;
    logic [31:0] instr_h = '0;
    logic        br_h = 1'b0;
    logic        jmp_h = 1'b0;
    logic [31:0] pc_h;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pcseq_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr        (instr),
        .branch_taken (branch_taken),
        .jump_en      (jump_en),
        .pc           (pc)
    );

    pcseq_top #(.RESET_PC(32'hA000_0000)) dut_hi (
        .clk          (clk),
        .rst_n        (rst_h),
        .instr        (instr_h),
        .branch_taken (br_h),
        .jump_en      (jmp_h),
        .pc           (pc_h)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pc actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] i, input logic b, input logic j);
        instr = i;
        branch_taken = b;
        jump_en = j;
    endtask

    task automatic drive_h(input logic [31:0] i, input logic b, input logic j);
        instr_h = i;
        br_h = b;
        jmp_h = j;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset value", pc, 32'h0000_0000);
        rst_n = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            chk("R2-table", pc, VEC[i].exp_pc);
            drive(VEC[i].instr, VEC[i].br, VEC[i].jmp);
            @(negedge clk);
        end
        chk("R2 after table", pc, 32'h0000_0044);

        // R1: reset while a target is parked discards it
        drive(32'h1000_0001, 1'b1, 1'b0);
        @(negedge clk);
        chk("R5 slot before reset", pc, 32'h0000_0048);
        drive(32'h0, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-slot", pc, 32'h0000_0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 parked target dropped", pc, 32'h0000_0004);
        @(negedge clk);
        chk("R1 sequential after reset", pc, 32'h0000_0008);

        // R4 region bits and R3 most negative offset, high reset address
        @(negedge clk);
        chk("R1 high reset value", pc_h, 32'hA000_0000);
        rst_h = 1'b1;
        drive_h(32'h0800_0010, 1'b0, 1'b1);
        @(negedge clk);
        chk("R5 high slot", pc_h, 32'hA000_0004);
        drive_h(32'h0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R4 region kept", pc_h, 32'hA000_0040);
        drive_h(32'h1000_8000, 1'b1, 1'b0);
        @(negedge clk);
        chk("R5 high slot 2", pc_h, 32'hA000_0044);
        drive_h(32'h0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R3 negative extreme", pc_h, 32'h9FFE_0044);
        @(negedge clk);
        chk("R6 sequential after landing", pc_h, 32'h9FFE_0048);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule